// File: doc/BRIEF.md
# Six-Pin GPIO Port With Pullup Control

This block is a six-pin bidirectional general-purpose I/O port controlled through a small register bus. It holds three registers: an output data latch, a per-pin direction register and a pullup register. The pullup register also carries a takeover bit for pin 4. The block drives the pad controls for each pin: output enable, output value and pullup enable. It samples the pad input levels through a two-flop synchronizer.

Software reads the data register to see a mix of values. An output pin returns its own latch. An input pin returns its synchronized pad level. Pullups are gated by direction in hardware, so a pin that is switched to output loses its pullup with no extra write. Pin 2 has no pullup at all. When the takeover bit is set, pin 4 stops carrying port data and drives a clock that enters the block at four times the bus rate.

The register bus has no flow control. A write takes effect on the rising edge where `bus_wr` is high. `bus_rdata` follows `bus_addr` combinationally.

Top module: `gpio_pull_port`

## Requirements
- R1: While reset is asserted and right after it, the data latch, direction and pullup registers are all 0. `pin_oe`, `pin_out` and `pin_pull_en` are all 0, and every register reads 0.
- R2: A write to offset 0 loads `bus_wdata[5:0]` into the data latch on that edge, whatever the direction bits are. `pin_out` shows the latch on the following cycle.
- R3: Reading offset 0 returns, for each pin i in [5:0], the latch bit when direction bit i is 1 and the synchronized pad level when it is 0.
- R4: A change on `pin_in` appears in the offset-0 readback of an input pin after exactly two rising edges, and not after one.
- R5: At offset 2, bits [5:0] are the per-pin pullup enables and bit 7 is the pin-4 takeover bit. Bit 6 always reads 0.
- R6: `pin_pull_en[i]` is 1 only when pullup bit i is 1 and direction bit i is 0. An output pin never has its pullup on.
- R7: `pin_pull_en[2]` is never asserted, for any register contents.
- R8: With the takeover bit set, `pin_oe[4]` is 1 and `pin_out[4]` equals `clk4x_in`. `pin_pull_en[4]` is 0, and bit 4 of the offset-0 read returns the latch bit.
- R9: Offset 1 is direction and offset 3 is unused. Reads of offset 3 return 0 and writes to it change nothing. Bits [7:6] of offsets 0 and 1 read 0.
- R10: When takeover is off, `pin_oe` equals the direction register, which a write to offset 1 loads from `bus_wdata[5:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 6 | Pad input levels (asynchronous) |
| clk4x_in | input | 1 | Clock routed to pin 4 when takeover is set |
| pin_oe | output | 6 | Per-pin output enable |
| pin_out | output | 6 | Per-pin output value |
| pin_pull_en | output | 6 | Per-pin pullup enable |

## Verification
A corrupted direction bit shows up in the same cycle in three places: `pin_oe`, the gating of `pin_pull_en`, and the source selected for that bit of the offset-0 read. A wrong latch bit is visible on `pin_out` one cycle after the write. A wrong synchronizer stage only shows as a readback that is one cycle early or late, so the bench samples the readback after both the first and the second edge. A stuck takeover bit shows immediately on `pin_oe[4]` and `pin_out[4]` when `clk4x_in` is toggled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NPIN   = 6;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA  = 2'd0,
    OFS_DIR   = 2'd1,
    OFS_PULL  = 2'd2,
    OFS_SPARE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NP      = NPIN,
  parameter int unsigned DW      = REG_W,
  parameter int unsigned ALT_BIT = REG_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [NP-1:0]     lat_q,
  output logic [NP-1:0]     dir_q,
  output logic [NP-1:0]     pue_q,
  output logic              alt_q
);
  localparam int unsigned SPARE_W = DW - NP;

  logic hit_data, hit_dir, hit_pull;
  assign hit_data = wr_en && (wr_addr == OFS_DATA);
  assign hit_dir  = wr_en && (wr_addr == OFS_DIR);
  assign hit_pull = wr_en && (wr_addr == OFS_PULL);

  // Upper bits other than the takeover bit have no storage.
  logic [SPARE_W-1:0] unused_hi;
  assign unused_hi = wr_data[DW-1:NP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      pue_q <= '0;
      alt_q <= 1'b0;
    end else begin
      if (hit_data) lat_q <= wr_data[NP-1:0];
      if (hit_dir)  dir_q <= wr_data[NP-1:0];
      if (hit_pull) begin
        pue_q <= wr_data[NP-1:0];
        alt_q <= wr_data[ALT_BIT];
      end
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_pkg::*;
#(
  parameter int unsigned NP      = NPIN,
  parameter int unsigned DW      = REG_W,
  parameter int unsigned ALT_PIN = 4,
  parameter int unsigned ALT_BIT = REG_W - 1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NP-1:0]     lat_q,
  input  logic [NP-1:0]     dir_q,
  input  logic [NP-1:0]     pue_q,
  input  logic              alt_q,
  input  logic [NP-1:0]     pin_sync,
  output logic [DW-1:0]     rd_data
);
  logic [NP-1:0] from_latch;
  logic [NP-1:0] port_view;

  // A pin taken over by the clock reads back its latch.
  always_comb begin
    from_latch = dir_q;
    from_latch[ALT_PIN] = dir_q[ALT_PIN] | alt_q;
  end

  for (genvar i = 0; i < NP; i++) begin : g_view
    assign port_view[i] = from_latch[i] ? lat_q[i] : pin_sync[i];
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFS_DATA: rd_data[NP-1:0] = port_view;
      OFS_DIR:  rd_data[NP-1:0] = dir_q;
      OFS_PULL: begin
        rd_data[NP-1:0] = pue_q;
        rd_data[ALT_BIT] = alt_q;
      end
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int unsigned NP         = 6,
  parameter int unsigned ALT_PIN    = 4,
  parameter int unsigned NOPULL_PIN = 2
) (
  input  logic [NP-1:0] lat_q,
  input  logic [NP-1:0] dir_q,
  input  logic [NP-1:0] pue_q,
  input  logic          alt_q,
  input  logic          clk4x_in,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_pull_en
);
  for (genvar i = 0; i < NP; i++) begin : g_pin
    if (i == ALT_PIN) begin : g_alt
      assign pin_oe[i]      = dir_q[i] | alt_q;
      assign pin_out[i]     = alt_q ? clk4x_in : lat_q[i];
      assign pin_pull_en[i] = pue_q[i] & ~dir_q[i] & ~alt_q;
    end else if (i == NOPULL_PIN) begin : g_nopull
      logic unused_pue;
      assign unused_pue     = pue_q[i];
      assign pin_oe[i]      = dir_q[i];
      assign pin_out[i]     = lat_q[i];
      assign pin_pull_en[i] = 1'b0;
    end else begin : g_plain
      assign pin_oe[i]      = dir_q[i];
      assign pin_out[i]     = lat_q[i];
      assign pin_pull_en[i] = pue_q[i] & ~dir_q[i];
    end
  end
endmodule

// File: rtl/gpio_pull_port.sv
module gpio_pull_port
  import gpio_pkg::*;
#(
  parameter int unsigned NP         = NPIN,
  parameter int unsigned DW         = REG_W,
  parameter int unsigned ALT_PIN    = 4,
  parameter int unsigned NOPULL_PIN = 2,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NP-1:0]     pin_in,
  input  logic              clk4x_in,
  output logic [NP-1:0]     pin_oe,
  output logic [NP-1:0]     pin_out,
  output logic [NP-1:0]     pin_pull_en
);
  localparam int unsigned ALT_BIT = DW - 1;

  logic [NP-1:0] lat_q, dir_q, pue_q, pin_sync;
  logic          alt_q;

  gpio_in_sync #(.W(NP), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pin_sync)
  );

  gpio_regs #(.NP(NP), .DW(DW), .ALT_BIT(ALT_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_addr(bus_addr), .wr_en(bus_wr),
    .wr_data(bus_wdata), .lat_q(lat_q), .dir_q(dir_q), .pue_q(pue_q),
    .alt_q(alt_q)
  );

  gpio_read_mux #(.NP(NP), .DW(DW), .ALT_PIN(ALT_PIN), .ALT_BIT(ALT_BIT)) u_rmux (
    .rd_addr(bus_addr), .lat_q(lat_q), .dir_q(dir_q), .pue_q(pue_q),
    .alt_q(alt_q), .pin_sync(pin_sync), .rd_data(bus_rdata)
  );

  gpio_pin_ctl #(.NP(NP), .ALT_PIN(ALT_PIN), .NOPULL_PIN(NOPULL_PIN)) u_pins (
    .lat_q(lat_q), .dir_q(dir_q), .pue_q(pue_q), .alt_q(alt_q),
    .clk4x_in(clk4x_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pull_en(pin_pull_en)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NP         = 6,
  parameter int unsigned DW         = 8,
  parameter int unsigned ALT_PIN    = 4,
  parameter int unsigned NOPULL_PIN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          clk4x_in,
  input logic [NP-1:0] pin_oe,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_pull_en,
  input logic          alt_q
);
  logic [NP-1:0] alt_mask;
  assign alt_mask = alt_q ? (NP'(1) << ALT_PIN) : '0;

  AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull_en & pin_oe) == '0); // R6
  AST_NO_PULL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_pull_en[NOPULL_PIN]); // R7
  AST_ALT_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q |-> (pin_oe[ALT_PIN] && pin_out[ALT_PIN] == clk4x_in && !pin_pull_en[ALT_PIN])); // R8
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (((pin_oe ^ $past(bus_wdata[NP-1:0])) & ~alt_mask) == '0)); // R10
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (((pin_out ^ $past(bus_wdata[NP-1:0])) & ~alt_mask) == '0)); // R2
  AST_GAP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[DW-2]); // R5
  AST_SPARE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R9
endmodule

bind gpio_pull_port gpio_port_chk #(
  .NP(NP), .DW(DW), .ALT_PIN(ALT_PIN), .NOPULL_PIN(NOPULL_PIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk4x_in(clk4x_in),
  .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull_en(pin_pull_en),
  .alt_q(alt_q)
);

// File: tb/tb_gpio_pull_port.sv
module tb_gpio_pull_port;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [1:0] waddr;
    logic [7:0] wdata;
    logic [5:0] pins;
    logic [1:0] raddr;
    logic [7:0] exp_rd;
    logic [5:0] exp_oe;
    logic [5:0] exp_out;
    logic [5:0] exp_pull;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'h2A, 6'h15, 2'd0, 8'h15, 6'h00, 6'h2A, 6'h00}, // R2 R3 latch while input
    '{2'd1, 8'h0F, 6'h30, 2'd0, 8'h3A, 6'h0F, 6'h2A, 6'h00}, // R3 R10 mixed read
    '{2'd2, 8'h7F, 6'h00, 2'd2, 8'h3F, 6'h0F, 6'h2A, 6'h30}, // R5 R6 bit6 dropped
    '{2'd1, 8'h00, 6'h3F, 2'd1, 8'h00, 6'h00, 6'h2A, 6'h3B}, // R6 R7 pin2 no pull
    '{2'd3, 8'hFF, 6'h3F, 2'd3, 8'h00, 6'h00, 6'h2A, 6'h3B}, // R9 spare offset
    '{2'd0, 8'hFF, 6'h00, 2'd0, 8'h00, 6'h00, 6'h3F, 6'h3B}, // R2 R9 top bits
    '{2'd1, 8'hC5, 6'h00, 2'd1, 8'h05, 6'h05, 6'h3F, 6'h3A}, // R9 R10 dir top bits
    '{2'd2, 8'h00, 6'h2A, 2'd0, 8'h2F, 6'h05, 6'h3F, 6'h00}  // R3 R6 pulls off
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = '0;
  logic       clk4x_in = 1'b0;
  logic [5:0] pin_oe, pin_out, pin_pull_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pull_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .clk4x_in(clk4x_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_pull_en(pin_pull_en)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2);
    @(negedge clk);
    check("R1", "oe", {2'b0, pin_oe}, 8'h00);
    check("R1", "pull", {2'b0, pin_pull_en}, 8'h00);
    check("R1", "out", {2'b0, pin_out}, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a);
      #1;
      check("R1", "reg read", bus_rdata, 8'h00);
    end

    // Table walk: write, present pins, read two edges later
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      pin_in = VECS[v].pins;
      bus_addr = VECS[v].waddr; bus_wdata = VECS[v].wdata; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = VECS[v].raddr;
      @(negedge clk);
      check("R2/R3/R5/R9 vec", "rdata", bus_rdata, VECS[v].exp_rd);
      check("R10 vec", "oe", {2'b0, pin_oe}, {2'b0, VECS[v].exp_oe});
      check("R2 vec", "out", {2'b0, pin_out}, {2'b0, VECS[v].exp_out});
      check("R6/R7 vec", "pull", {2'b0, pin_pull_en}, {2'b0, VECS[v].exp_pull});
    end

    // R4: two-edge synchronizer latency
    bus_write(2'd1, 8'h00);
    pin_in = 6'h00;
    @(negedge clk); @(negedge clk);
    bus_addr = 2'd0; pin_in = 6'h3F;
    @(negedge clk);
    check("R4", "after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    check("R4", "after two edges", bus_rdata, 8'h3F);

    // R8: clock takeover of pin 4 (latch 3F, dir 0)
    bus_write(2'd2, 8'h90);
    check("R8", "oe", {2'b0, pin_oe}, 8'h10);
    check("R8", "pull", {2'b0, pin_pull_en}, 8'h00);
    check("R8", "out clk low", {2'b0, pin_out}, 8'h2F);
    bus_addr = 2'd2; #1;
    check("R5", "alt bit read", bus_rdata, 8'h90);
    pin_in = 6'h00;
    bus_addr = 2'd0;
    @(negedge clk); @(negedge clk);
    check("R8", "bit4 reads latch", bus_rdata, 8'h10);
    clk4x_in = 1'b1; #1;
    check("R8", "out clk high", {2'b0, pin_out}, 8'h3F);
    clk4x_in = 1'b0;
    bus_write(2'd2, 8'h10);
    check("R8", "release pull", {2'b0, pin_pull_en}, 8'h10);
    check("R8", "release oe", {2'b0, pin_oe}, 8'h00);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0; bus_addr = 2'd2; #1;
    check("R1", "mid reset pull reg", bus_rdata, 8'h00);
    check("R1", "mid reset out", {2'b0, pin_out}, 8'h00);
    check("R1", "mid reset pull", {2'b0, pin_pull_en}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule